// File: doc/BRIEF.md
# Relocatable On-Chip Memory Window Decoder

This block places a small on-chip RAM into the address space through two windows that software can move. One window serves instruction fetches and the other serves data loads and stores. Each window has a base register and a control register on a narrow device-control register bus. A window decodes only while its enable bit is set. Both windows address the same physical storage, so a word stored through the data window can be fetched through the instruction window.

For every request the decoder compares the top six address bits with the base of the window on that side. On a match it raises a hit in the same cycle and the RAM serves the access. Read data appears one cycle later. On a mismatch the hit stays low and the access is left to the rest of the system. Window bases are aligned to 64 MiB. Inside a window, address bits [11:2] pick one of 1024 32-bit words, and the 4 KiB of storage repeats across the whole window.

Top module: `ocm_window_dec`

## Requirements
- R1: The register block claims four control addresses. 0x018 is the instruction base, 0x019 the instruction control, 0x01A the data base and 0x01B the data control. Only a request to one of these four raises `dcr_ack_o`. A read of any other address returns ack 0 and data 0. A write to any other address changes no register.
- R2: A write to a base register keeps only bits [31:26]. A read returns those bits with all other bits zero.
- R3: A write to a control register keeps only bits [31:30]. Bit 31 is the window enable. Bit 30 is stored and read back but does not enable decoding.
- R4: After reset all four registers read zero and neither side produces a hit.
- R5: A side raises its hit in the cycle of its request exactly when that side's window is enabled and address bits [31:26] equal the window base. Otherwise the hit is 0.
- R6: Instruction requests are checked only against the instruction window. Data requests are checked only against the data window.
- R7: In a hit, address bits [11:2] select the word and bits [25:12] are ignored. Read data is presented on the cycle after a hitting read. On every other cycle the read data output is zero, including the cycle after a data write.
- R8: A data write that hits stores its word. Both windows read the same storage from offset zero.
- R9: When both windows are enabled at the same base, disabling either window leaves the other window hitting.
- R10: A register write takes effect for requests in the following cycle. A request in the same cycle as the write decodes with the old settings.
- R11: When an instruction fetch and a data write hit the same word in one cycle, the fetch returns the old word. The next fetch returns the new word.
- R12: A data write that misses leaves the storage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dcr_req_i | input | 1 | Register bus request |
| dcr_we_i | input | 1 | Register bus write (1) or read (0) |
| dcr_addr_i | input | REG_ADDR_W | Register bus address |
| dcr_wdata_i | input | 32 | Register write data |
| dcr_ack_o | output | 1 | Address claimed by this block |
| dcr_rdata_o | output | 32 | Register read data, same cycle |
| ifetch_req_i | input | 1 | Instruction fetch request |
| ifetch_addr_i | input | 32 | Instruction fetch byte address |
| ifetch_hit_o | output | 1 | Fetch falls in the instruction window |
| ifetch_rdata_o | output | 32 | Fetched word, cycle after hit |
| dacc_req_i | input | 1 | Data access request |
| dacc_we_i | input | 1 | Data write (1) or read (0) |
| dacc_addr_i | input | 32 | Data byte address |
| dacc_wdata_i | input | 32 | Data write word |
| dacc_hit_o | output | 1 | Access falls in the data window |
| dacc_rdata_o | output | 32 | Read word, cycle after a hitting read |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a fetch and a data write hit the same word together. The bench drives both requests in one cycle and expects the fetch to return the word stored before that cycle, then returns the new word on the next fetch. In the second, a control or base register write coincides with a request. The bench's model decodes that request with the settings from before the write, and the following request with the new settings, so the hit flag shows which ordering the RTL used.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned BASE_W    = 6;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_I    = 0;
  localparam int unsigned SIDE_D    = 1;

  typedef struct packed {
    logic              en;
    logic              aux;
    logic [BASE_W-1:0] base;
  } ocm_win_t;

  typedef enum logic [1:0] {
    SEL_IBASE = 2'd0,
    SEL_ICTRL = 2'd1,
    SEL_DBASE = 2'd2,
    SEL_DCTRL = 2'd3
  } ocm_reg_e;
endpackage

// File: rtl/ocm_regs.sv
module ocm_regs
  import ocm_pkg::*;
#(
  parameter int unsigned            REG_ADDR_W = 10,
  parameter logic [REG_ADDR_W-1:0]  BLOCK_ADDR = 10'h018
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dcr_req_i,
  input  logic                  dcr_we_i,
  input  logic [REG_ADDR_W-1:0] dcr_addr_i,
  input  logic [DATA_W-1:0]     dcr_wdata_i,
  output logic                  dcr_ack_o,
  output logic [DATA_W-1:0]     dcr_rdata_o,
  output ocm_win_t              i_win_o,
  output ocm_win_t              d_win_o
);
  logic     claim;
  ocm_reg_e sel;
  ocm_win_t i_win_q, d_win_q;
  logic     unused_wdata;

  assign claim = dcr_req_i && (dcr_addr_i[REG_ADDR_W-1:2] == BLOCK_ADDR[REG_ADDR_W-1:2]);
  assign sel   = ocm_reg_e'(dcr_addr_i[1:0]);
  assign unused_wdata = ^dcr_wdata_i[DATA_W-BASE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_win_q <= '0;
      d_win_q <= '0;
    end else if (claim && dcr_we_i) begin
      case (sel)
        SEL_IBASE: i_win_q.base <= dcr_wdata_i[DATA_W-1 -: BASE_W];
        SEL_ICTRL: begin
          i_win_q.en  <= dcr_wdata_i[DATA_W-1];
          i_win_q.aux <= dcr_wdata_i[DATA_W-2];
        end
        SEL_DBASE: d_win_q.base <= dcr_wdata_i[DATA_W-1 -: BASE_W];
        default: begin
          d_win_q.en  <= dcr_wdata_i[DATA_W-1];
          d_win_q.aux <= dcr_wdata_i[DATA_W-2];
        end
      endcase
    end
  end

  always_comb begin
    dcr_rdata_o = '0;
    if (claim && !dcr_we_i) begin
      case (sel)
        SEL_IBASE: dcr_rdata_o[DATA_W-1 -: BASE_W] = i_win_q.base;
        SEL_ICTRL: dcr_rdata_o[DATA_W-1 -: 2] = {i_win_q.en, i_win_q.aux};
        SEL_DBASE: dcr_rdata_o[DATA_W-1 -: BASE_W] = d_win_q.base;
        default:   dcr_rdata_o[DATA_W-1 -: 2] = {d_win_q.en, d_win_q.aux};
      endcase
    end
  end

  assign dcr_ack_o = claim;
  assign i_win_o   = i_win_q;
  assign d_win_o   = d_win_q;
endmodule

// File: rtl/ocm_win_match.sv
module ocm_win_match
  import ocm_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  ocm_win_t          cfg_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic unused_bits;

  // bits between the word index and the base field mirror the storage
  assign unused_bits = ^{addr_i[ADDR_W-BASE_W-1:IDX_W+2], addr_i[1:0], cfg_i.aux};
  assign hit_o = req_i && cfg_i.en && (addr_i[ADDR_W-1 -: BASE_W] == cfg_i.base);
  assign idx_o = addr_i[IDX_W+1:2];
endmodule

// File: rtl/ocm_ram.sv
module ocm_ram
  import ocm_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [IDX_W-1:0]  b_idx_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] a_q, b_q;
  logic              a_vld_q, b_vld_q;

  // reads sample the array before this edge's write lands
  always_ff @(posedge clk_i) begin
    if (b_en_i && b_we_i) mem_q[b_idx_i] <= b_wdata_i;
    if (a_en_i) a_q <= mem_q[a_idx_i];
    if (b_en_i && !b_we_i) b_q <= mem_q[b_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_q <= 1'b0;
      b_vld_q <= 1'b0;
    end else begin
      a_vld_q <= a_en_i;
      b_vld_q <= b_en_i && !b_we_i;
    end
  end

  assign a_rdata_o = a_vld_q ? a_q : '0;
  assign b_rdata_o = b_vld_q ? b_q : '0;
endmodule

// File: rtl/ocm_window_dec.sv
module ocm_window_dec
  import ocm_pkg::*;
#(
  parameter int unsigned           REG_ADDR_W = 10,
  parameter logic [REG_ADDR_W-1:0] BLOCK_ADDR = 10'h018,
  parameter int unsigned           RAM_BYTES  = 4096
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dcr_req_i,
  input  logic                  dcr_we_i,
  input  logic [REG_ADDR_W-1:0] dcr_addr_i,
  input  logic [DATA_W-1:0]     dcr_wdata_i,
  output logic                  dcr_ack_o,
  output logic [DATA_W-1:0]     dcr_rdata_o,
  input  logic                  ifetch_req_i,
  input  logic [ADDR_W-1:0]     ifetch_addr_i,
  output logic                  ifetch_hit_o,
  output logic [DATA_W-1:0]     ifetch_rdata_o,
  input  logic                  dacc_req_i,
  input  logic                  dacc_we_i,
  input  logic [ADDR_W-1:0]     dacc_addr_i,
  input  logic [DATA_W-1:0]     dacc_wdata_i,
  output logic                  dacc_hit_o,
  output logic [DATA_W-1:0]     dacc_rdata_o
);
  localparam int unsigned RAM_WORDS = RAM_BYTES / (DATA_W / 8);
  localparam int unsigned IDX_W     = $clog2(RAM_WORDS);

  ocm_win_t [NUM_SIDES-1:0]             side_cfg;
  logic     [NUM_SIDES-1:0]             side_req;
  logic     [NUM_SIDES-1:0][ADDR_W-1:0] side_addr;
  logic     [NUM_SIDES-1:0]             side_hit;
  logic     [NUM_SIDES-1:0][IDX_W-1:0]  side_idx;

  ocm_regs #(
    .REG_ADDR_W (REG_ADDR_W),
    .BLOCK_ADDR (BLOCK_ADDR)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dcr_req_i   (dcr_req_i),
    .dcr_we_i    (dcr_we_i),
    .dcr_addr_i  (dcr_addr_i),
    .dcr_wdata_i (dcr_wdata_i),
    .dcr_ack_o   (dcr_ack_o),
    .dcr_rdata_o (dcr_rdata_o),
    .i_win_o     (side_cfg[SIDE_I]),
    .d_win_o     (side_cfg[SIDE_D])
  );

  assign side_req[SIDE_I]  = ifetch_req_i;
  assign side_req[SIDE_D]  = dacc_req_i;
  assign side_addr[SIDE_I] = ifetch_addr_i;
  assign side_addr[SIDE_D] = dacc_addr_i;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    ocm_win_match #(
      .IDX_W (IDX_W)
    ) u_match (
      .req_i  (side_req[s]),
      .addr_i (side_addr[s]),
      .cfg_i  (side_cfg[s]),
      .hit_o  (side_hit[s]),
      .idx_o  (side_idx[s])
    );
  end

  ocm_ram #(
    .WORDS (RAM_WORDS)
  ) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_en_i    (side_hit[SIDE_I]),
    .a_idx_i   (side_idx[SIDE_I]),
    .a_rdata_o (ifetch_rdata_o),
    .b_en_i    (side_hit[SIDE_D]),
    .b_we_i    (dacc_we_i),
    .b_idx_i   (side_idx[SIDE_D]),
    .b_wdata_i (dacc_wdata_i),
    .b_rdata_o (dacc_rdata_o)
  );

  assign ifetch_hit_o = side_hit[SIDE_I];
  assign dacc_hit_o   = side_hit[SIDE_D];
endmodule

// File: rtl/ocm_window_dec_chk.sv
module ocm_window_dec_chk
  import ocm_pkg::*;
#(
  parameter int unsigned           REG_ADDR_W = 10,
  parameter logic [REG_ADDR_W-1:0] BLOCK_ADDR = 10'h018
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  dcr_req_i,
  input logic                  dcr_we_i,
  input logic [REG_ADDR_W-1:0] dcr_addr_i,
  input logic [DATA_W-1:0]     dcr_wdata_i,
  input logic                  dcr_ack_o,
  input logic                  ifetch_req_i,
  input logic [ADDR_W-1:0]     ifetch_addr_i,
  input logic                  ifetch_hit_o,
  input logic [DATA_W-1:0]     ifetch_rdata_o,
  input logic                  dacc_req_i,
  input logic                  dacc_hit_o,
  input ocm_win_t              i_win_i,
  input ocm_win_t              d_win_i
);
  logic wr_ibase, wr_ictrl;
  assign wr_ibase = dcr_req_i && dcr_we_i && (dcr_addr_i == BLOCK_ADDR);
  assign wr_ictrl = dcr_req_i && dcr_we_i && (dcr_addr_i == BLOCK_ADDR + REG_ADDR_W'(1));

  assert_ack_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcr_ack_o |-> dcr_req_i);

  assert_base_keeps_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ibase |=> i_win_i.base == $past(dcr_wdata_i[DATA_W-1 -: BASE_W]));

  assert_ctrl_enable_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ictrl |=> i_win_i.en == $past(dcr_wdata_i[DATA_W-1]));

  assert_reset_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!i_win_i.en && !d_win_i.en));

  assert_hit_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifetch_hit_o |-> (ifetch_req_i && i_win_i.en &&
                      ifetch_addr_i[ADDR_W-1 -: BASE_W] == i_win_i.base));

  assert_data_side_own_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dacc_hit_o |-> (dacc_req_i && d_win_i.en));

  assert_miss_rdata_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ifetch_hit_o) |-> ifetch_rdata_o == '0);

  assert_disable_next_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ictrl && !dcr_wdata_i[DATA_W-1]) |=> !ifetch_hit_o);
endmodule

bind ocm_window_dec ocm_window_dec_chk #(
  .REG_ADDR_W (REG_ADDR_W),
  .BLOCK_ADDR (BLOCK_ADDR)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dcr_req_i      (dcr_req_i),
  .dcr_we_i       (dcr_we_i),
  .dcr_addr_i     (dcr_addr_i),
  .dcr_wdata_i    (dcr_wdata_i),
  .dcr_ack_o      (dcr_ack_o),
  .ifetch_req_i   (ifetch_req_i),
  .ifetch_addr_i  (ifetch_addr_i),
  .ifetch_hit_o   (ifetch_hit_o),
  .ifetch_rdata_o (ifetch_rdata_o),
  .dacc_req_i     (dacc_req_i),
  .dacc_hit_o     (dacc_hit_o),
  .i_win_i        (side_cfg[0]),
  .d_win_i        (side_cfg[1])
);

// File: tb/ocm_window_dec_tb.sv
`timescale 1ns/1ps
module ocm_window_dec_tb;
  localparam logic [9:0] A_IBASE = 10'h018;
  localparam logic [9:0] A_ICTRL = 10'h019;
  localparam logic [9:0] A_DBASE = 10'h01A;
  localparam logic [9:0] A_DCTRL = 10'h01B;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dcr_req = 0, dcr_we = 0;
  logic [9:0]  dcr_addr = '0;
  logic [31:0] dcr_wdata = '0;
  logic        dcr_ack;
  logic [31:0] dcr_rdata;
  logic        if_req = 0;
  logic [31:0] if_addr = '0;
  logic        if_hit;
  logic [31:0] if_rdata;
  logic        d_req = 0, d_we = 0;
  logic [31:0] d_addr = '0, d_wdata = '0;
  logic        d_hit;
  logic [31:0] d_rdata;

  always #2.5 clk_i = ~clk_i;

  ocm_window_dec u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dcr_req_i(dcr_req), .dcr_we_i(dcr_we), .dcr_addr_i(dcr_addr),
    .dcr_wdata_i(dcr_wdata), .dcr_ack_o(dcr_ack), .dcr_rdata_o(dcr_rdata),
    .ifetch_req_i(if_req), .ifetch_addr_i(if_addr), .ifetch_hit_o(if_hit),
    .ifetch_rdata_o(if_rdata),
    .dacc_req_i(d_req), .dacc_we_i(d_we), .dacc_addr_i(d_addr),
    .dacc_wdata_i(d_wdata), .dacc_hit_o(d_hit), .dacc_rdata_o(d_rdata)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_ib = '0, m_ic = '0, m_db = '0, m_dc = '0;
  logic [31:0] m_mem [1024];
  bit          m_known [1024];

  typedef struct {
    bit          side;
    logic [31:0] exp;
    string       rq;
  } item_t;
  item_t sb[$];

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic bit claimed(logic [9:0] a);
    return a[9:2] == A_IBASE[9:2];
  endfunction

  function automatic logic [31:0] reg_val(logic [9:0] a);
    case (a[1:0])
      2'd0: return m_ib;
      2'd1: return m_ic;
      2'd2: return m_db;
      default: return m_dc;
    endcase
  endfunction

  // inputs are set just after a negedge; checks, model update, advance
  task automatic tick(string rq);
    bit eih, edh, ack;
    int iw, dw;
    #1;
    eih = if_req && m_ic[31] && (if_addr[31:26] == m_ib[31:26]);
    edh = d_req && m_dc[31] && (d_addr[31:26] == m_db[31:26]);
    iw = int'(if_addr[11:2]);
    dw = int'(d_addr[11:2]);
    if (if_req) chk(if_hit === eih, {rq, " ifetch hit"}, 32'(if_hit), 32'(eih));
    if (d_req)  chk(d_hit === edh, {rq, " data hit"}, 32'(d_hit), 32'(edh));
    if (dcr_req) begin
      ack = claimed(dcr_addr);
      chk(dcr_ack === ack, {rq, " ack"}, 32'(dcr_ack), 32'(ack));
      if (!dcr_we)
        chk(dcr_rdata === (ack ? reg_val(dcr_addr) : 32'h0), {rq, " reg rdata"},
            dcr_rdata, ack ? reg_val(dcr_addr) : 32'h0);
    end
    if (if_req) begin
      if (!eih) sb.push_back('{0, 32'h0, rq});
      else if (m_known[iw]) sb.push_back('{0, m_mem[iw], rq});
    end
    if (d_req) begin
      if (!edh || d_we) sb.push_back('{1, 32'h0, rq});
      else if (m_known[dw]) sb.push_back('{1, m_mem[dw], rq});
    end
    if (dcr_req && dcr_we && claimed(dcr_addr)) begin
      case (dcr_addr[1:0])
        2'd0: m_ib = dcr_wdata & 32'hFC00_0000;
        2'd1: m_ic = dcr_wdata & 32'hC000_0000;
        2'd2: m_db = dcr_wdata & 32'hFC00_0000;
        default: m_dc = dcr_wdata & 32'hC000_0000;
      endcase
    end
    if (edh && d_we) begin
      m_mem[dw] = d_wdata;
      m_known[dw] = 1;
    end
    @(negedge clk_i);
    dcr_req = 0; dcr_we = 0; if_req = 0; d_req = 0; d_we = 0;
  endtask

  task automatic dcr_wr(logic [9:0] a, logic [31:0] v, string rq);
    dcr_req = 1; dcr_we = 1; dcr_addr = a; dcr_wdata = v; tick(rq);
  endtask
  task automatic dcr_rd(logic [9:0] a, string rq);
    dcr_req = 1; dcr_we = 0; dcr_addr = a; tick(rq);
  endtask
  task automatic fetch(logic [31:0] a, string rq);
    if_req = 1; if_addr = a; tick(rq);
  endtask
  task automatic dwr(logic [31:0] a, logic [31:0] v, string rq);
    d_req = 1; d_we = 1; d_addr = a; d_wdata = v; tick(rq);
  endtask
  task automatic drd(logic [31:0] a, string rq);
    d_req = 1; d_we = 0; d_addr = a; tick(rq);
  endtask

  // monitor: read data belongs to the request one edge earlier
  always @(posedge clk_i) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.side == 0)
        chk(if_rdata === it.exp, {it.rq, " ifetch rdata"}, if_rdata, it.exp);
      else
        chk(d_rdata === it.exp, {it.rq, " data rdata"}, d_rdata, it.exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) m_known[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R4 reset state
    fetch(32'h0000_0010, "R4");
    drd(32'h0000_0010, "R4");
    dcr_rd(A_IBASE, "R4");
    dcr_rd(A_ICTRL, "R4");
    dcr_rd(A_DCTRL, "R4");

    // R2 / R3 masking
    dcr_wr(A_IBASE, 32'hFFFF_FFFF, "R2");
    dcr_rd(A_IBASE, "R2");
    dcr_wr(A_ICTRL, 32'h7FFF_FFFF, "R3");
    dcr_rd(A_ICTRL, "R3");
    fetch(32'hFC00_0000, "R3");

    // R1 unclaimed addresses
    dcr_rd(10'h01C, "R1");
    dcr_rd(10'h118, "R1");
    dcr_wr(10'h017, 32'hFFFF_FFFF, "R1");
    dcr_wr(10'h11A, 32'hFFFF_FFFF, "R1");
    dcr_rd(A_DBASE, "R1");

    // both windows at 0x0400_0000
    dcr_wr(A_IBASE, 32'h0400_0000, "R5");
    dcr_wr(A_ICTRL, 32'h8000_0000, "R5");
    dcr_wr(A_DBASE, 32'h0400_0000, "R5");
    dcr_wr(A_DCTRL, 32'h8000_0000, "R5");

    // R8 alias, R7 mirror and index, R5 misses
    dwr(32'h0400_0010, 32'hA5A5_0001, "R8");
    fetch(32'h0400_0010, "R8");
    drd(32'h0400_0010, "R8");
    fetch(32'h0400_5010, "R7");
    drd(32'h07FF_F010, "R7");
    dwr(32'h0400_0FFC, 32'h1234_5678, "R7");
    fetch(32'h0400_0FFC, "R7");
    drd(32'h0400_0FFC, "R7");
    fetch(32'h0800_0010, "R5");
    fetch(32'h0000_0010, "R5");

    // R6 sides decode independently
    dcr_wr(A_DBASE, 32'h0800_0000, "R6");
    drd(32'h0400_0010, "R6");
    fetch(32'h0400_0010, "R6");
    fetch(32'h0800_0010, "R6");
    drd(32'h0800_0010, "R6");

    // R9 shared base, disable one side
    dcr_wr(A_DBASE, 32'h0400_0000, "R9");
    dcr_wr(A_DCTRL, 32'h0000_0000, "R9");
    fetch(32'h0400_0010, "R9");
    drd(32'h0400_0010, "R9");
    dcr_wr(A_DCTRL, 32'h8000_0000, "R9");
    dcr_wr(A_ICTRL, 32'h0000_0000, "R9");
    drd(32'h0400_0010, "R9");
    fetch(32'h0400_0010, "R9");

    // R10 register write and request in one cycle
    dcr_req = 1; dcr_we = 1; dcr_addr = A_ICTRL; dcr_wdata = 32'h8000_0000;
    if_req = 1; if_addr = 32'h0400_0010; tick("R10");
    fetch(32'h0400_0010, "R10");
    dcr_req = 1; dcr_we = 1; dcr_addr = A_ICTRL; dcr_wdata = 32'h0;
    if_req = 1; if_addr = 32'h0400_0010; tick("R10");
    fetch(32'h0400_0010, "R10");
    dcr_req = 1; dcr_we = 1; dcr_addr = A_DBASE; dcr_wdata = 32'h0C00_0000;
    d_req = 1; d_we = 0; d_addr = 32'h0400_0010; tick("R10");
    drd(32'h0400_0010, "R10");
    drd(32'h0C00_0010, "R10");
    dcr_wr(A_DBASE, 32'h0400_0000, "R10");
    dcr_wr(A_ICTRL, 32'h8000_0000, "R10");

    // R11 fetch and data write to one word in one cycle
    dwr(32'h0400_0020, 32'hCCCC_0003, "R11");
    d_req = 1; d_we = 1; d_addr = 32'h0400_0020; d_wdata = 32'hBBBB_0002;
    if_req = 1; if_addr = 32'h0400_0020; tick("R11");
    fetch(32'h0400_0020, "R11");

    // R12 missing write leaves storage alone
    dwr(32'h0800_0020, 32'hDEAD_0004, "R12");
    drd(32'h0400_0020, "R12");
    fetch(32'h0400_0020, "R12");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule